// File: doc/BRIEF.md
# Total-Store-Order Store Buffer

This block sits between one processor core and the shared bus. It holds the stores and atomic operations that the core has committed and writes them out in program order. The core does not have to wait for the bus on an ordinary store: once the buffer takes a store, the core moves on.

Loads are not queued. A load whose word address matches no buffered entry goes straight to the bus and can overtake older writes. A load whose word address matches a buffered entry is held until every matching entry has drained. An atomic is queued behind the older writes. The core gets no response, and no new request is taken, until the atomic's own bus transaction has completed.

A parameter turns the bypass off. In that configuration a load waits until the buffer is empty, so every access reaches the bus in program order and the core sees a sequentially consistent memory. The buffer depth, the address width and the data width are parameters. Bus transfers complete in the cycle where request and grant are both high.

Top module: `tso_store_buffer`

## Requirements
- R1: Stores and atomics appear on the bus as writes (`bus_we`=1) in exactly the order the core handed them over, each with its own address and data.
- R2: The request encoding on `req_op` is 2'b00 load, 2'b01 store, 2'b10 atomic. A store or atomic is accepted (`req_ready`=1) in the same cycle it is presented whenever the buffer has a free slot and no atomic is pending, whatever the state of `bus_gnt`.
- R3: When all DEPTH slots hold entries, `req_ready` stays low for a store or atomic until a slot frees.
- R4: With bypass enabled, a load whose word address differs from every buffered entry is issued and completed while older writes are still waiting for the bus.
- R5: A load whose word address matches a buffered entry is not issued until every matching entry has been written to the bus. It then issues ahead of any remaining unrelated writes.
- R6: Matching ignores the byte-offset bits below the data word (log2(DATA_W/8) bits). Two addresses that differ only there count as the same location.
- R7: While an atomic is buffered, `req_ready` is low for every request. The atomic's response arrives only after all older writes and the atomic's own bus transfer have completed.
- R8: With bypass disabled, a load is not put on the bus while any store or atomic is buffered.
- R9: For a load or an atomic, `rsp_valid` is high for exactly one cycle, the cycle after the granted bus transfer, and `rsp_rdata` then holds the `bus_rdata` of that transfer.
- R10: After reset the buffer is empty, `bus_req` and `rsp_valid` are low, and a store is accepted at once.
- R11: The reserved code 2'b11 on `req_op` is never accepted and puts nothing on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_op | input | 2 | Request kind: 00 load, 01 store, 10 atomic, 11 reserved |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write data for a store or an atomic |
| req_ready | output | 1 | Request taken this cycle |
| rsp_valid | output | 1 | Load or atomic result valid |
| rsp_rdata | output | DATA_W | Load or atomic result |
| bus_req | output | 1 | Bus transfer requested |
| bus_we | output | 1 | Transfer is a write (store or atomic) |
| bus_atomic | output | 1 | Transfer is an atomic read-modify-write |
| bus_addr | output | ADDR_W | Transfer address |
| bus_wdata | output | DATA_W | Transfer write data |
| bus_gnt | input | 1 | Transfer completes this cycle |
| bus_rdata | input | DATA_W | Read data, valid with `bus_gnt` |

## Verification
A sweep fills the buffer to every level from one to DEPTH entries. For each level it presents a load that hits each buffered slot in turn, plus one load that hits none. The hits are made with byte offsets, so the test also shows that matching works on whole words. The bench then counts how many writes went out before the load was answered: zero for a miss, and the hit slot's position plus one for a hit. This separates correct bypass from blocking on every load, from blocking too briefly, and from draining the whole buffer first. Further runs cover a full buffer, an atomic queued behind a store while the core keeps asking, the reserved code, and a second instance with bypass off, where a load to an unrelated address must still wait for the write ahead of it.

// File: rtl/tsob_pkg.sv
package tsob_pkg;
   typedef enum logic [1:0] {
      OP_LOAD   = 2'b00,
      OP_STORE  = 2'b01,
      OP_ATOMIC = 2'b10,
      OP_RSVD   = 2'b11
   } tsob_op_e;
endpackage

// File: rtl/tsob_fifo.sv
module tsob_fifo #(
   parameter int DEPTH   = 4,
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int CMP_LSB = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [DATA_W-1:0] push_data,
   input  logic              push_atom,
   input  logic              pop,
   output logic              full,
   output logic              empty,
   output logic [ADDR_W-1:0] head_addr,
   output logic [DATA_W-1:0] head_data,
   output logic              head_atom,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              probe_hit,
   output logic              atom_pending
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("tsob_fifo: DEPTH must be at least 1");
      end
      if (CMP_LSB >= ADDR_W) begin : g_bad_lsb
         $error("tsob_fifo: CMP_LSB must be below ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];
   logic [DEPTH-1:0]  vld_q, atom_q, hit_vec;
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  cnt_q;

   function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
         vld_q  <= '0;
         atom_q <= '0;
      end else begin
         if (push) begin
            vld_q[wr_ptr]  <= 1'b1;
            atom_q[wr_ptr] <= push_atom;
            wr_ptr         <= ptr_inc(wr_ptr);
         end
         if (pop) begin
            vld_q[rd_ptr] <= 1'b0;
            rd_ptr        <= ptr_inc(rd_ptr);
         end
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[wr_ptr] <= push_addr;
         data_q[wr_ptr] <= push_data;
      end
   end

   // One word-address comparator per slot
   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit_vec[g] = vld_q[g] &&
         (addr_q[g][ADDR_W-1:CMP_LSB] == probe_addr[ADDR_W-1:CMP_LSB]);
   end

   assign probe_hit    = |hit_vec;
   assign atom_pending = |(vld_q & atom_q);
   assign full         = (cnt_q == CNT_W'(DEPTH));
   assign empty        = (cnt_q == '0);
   assign head_addr    = addr_q[rd_ptr];
   assign head_data    = data_q[rd_ptr];
   assign head_atom    = atom_q[rd_ptr];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R3
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R1
   AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !pop) |=> $stable(cnt_q)); // R2
   AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !probe_hit); // R4
endmodule

// File: rtl/tsob_issue.sv
module tsob_issue #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              ld_block,
   input  logic              q_empty,
   input  logic [ADDR_W-1:0] head_addr,
   input  logic [DATA_W-1:0] head_data,
   input  logic              head_atom,
   input  logic              bus_gnt,
   output logic              bus_req,
   output logic              bus_we,
   output logic              bus_atomic,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              ld_go,
   output logic              q_pop
);
   logic ld_sel, wr_sel;

   // An eligible load takes the bus ahead of the queue head
   always_comb begin
      ld_sel     = ld_valid && !ld_block;
      wr_sel     = !ld_sel && !q_empty;
      bus_req    = ld_sel || wr_sel;
      bus_we     = wr_sel;
      bus_atomic = wr_sel && head_atom;
      bus_addr   = ld_sel ? ld_addr : head_addr;
      bus_wdata  = head_data;
      ld_go      = ld_sel && bus_gnt;
      q_pop      = wr_sel && bus_gnt;
   end
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer
   import tsob_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int DEPTH     = 4,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic              bus_atomic,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic [DATA_W-1:0] bus_rdata
);
   localparam int CMP_LSB = $clog2(DATA_W / 8);

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("tso_store_buffer: DATA_W must be a multiple of 8");
      end
   endgenerate

   tsob_op_e op;
   logic     is_wr, push, ld_valid, ld_block, ld_go, q_pop;
   logic     full, q_empty, head_atom, probe_hit, atom_pend;
   logic [ADDR_W-1:0] head_addr;
   logic [DATA_W-1:0] head_data;
   logic              rsp_valid_q;
   logic [DATA_W-1:0] rsp_rdata_q;

   assign op       = tsob_op_e'(req_op);
   assign is_wr    = req_valid && (op == OP_STORE || op == OP_ATOMIC);
   assign push     = is_wr && !full && !atom_pend;
   assign ld_valid = req_valid && (op == OP_LOAD) && !atom_pend;

   // The consistency variant decides what holds a load back
   generate
      if (BYPASS_EN) begin : g_tso
         assign ld_block = probe_hit;
      end else begin : g_sc
         assign ld_block = !q_empty;
      end
   endgenerate

   tsob_fifo #(
      .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_LSB(CMP_LSB)
   ) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(push), .push_addr(req_addr), .push_data(req_wdata),
      .push_atom(op == OP_ATOMIC), .pop(q_pop),
      .full(full), .empty(q_empty),
      .head_addr(head_addr), .head_data(head_data), .head_atom(head_atom),
      .probe_addr(req_addr), .probe_hit(probe_hit), .atom_pending(atom_pend)
   );

   tsob_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_issue (
      .ld_valid(ld_valid), .ld_addr(req_addr), .ld_block(ld_block),
      .q_empty(q_empty), .head_addr(head_addr), .head_data(head_data),
      .head_atom(head_atom), .bus_gnt(bus_gnt),
      .bus_req(bus_req), .bus_we(bus_we), .bus_atomic(bus_atomic),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .ld_go(ld_go), .q_pop(q_pop)
   );

   assign req_ready = push || ld_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_rdata_q <= '0;
      end else begin
         rsp_valid_q <= ld_go || (q_pop && head_atom);
         if (ld_go || (q_pop && head_atom)) rsp_rdata_q <= bus_rdata;
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_rdata = rsp_rdata_q;

   AST_LOAD_NO_HAZARD: assert property (@(posedge clk) disable iff (!rst_n)
      ld_go |-> !probe_hit); // R5
   AST_ATOMIC_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
      atom_pend |-> !req_ready); // R7
   AST_RSP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(bus_req && bus_gnt && (!bus_we || bus_atomic))); // R9
   AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'b11) |-> !req_ready); // R11

   generate
      if (!BYPASS_EN) begin : g_sc_chk
         AST_SC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_req && !bus_we) |-> q_empty); // R8
      end
   endgenerate
endmodule

// File: tb/tb_tso_store_buffer.sv
`timescale 1ns/1ps
module tb_tso_store_buffer;
   localparam int AW = 8;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   // bypass instance
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'b00;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rsp_valid, bus_req, bus_we, bus_atomic, bus_gnt;
   logic [DW-1:0] rsp_rdata, bus_wdata, bus_rdata;
   logic [AW-1:0] bus_addr;
   logic          gnt_all = 1'b0, gnt_rd = 1'b0;

   // sequentially consistent instance
   logic          s_req_valid = 1'b0;
   logic [1:0]    s_req_op = 2'b00;
   logic [AW-1:0] s_req_addr = '0;
   logic [DW-1:0] s_req_wdata = '0;
   logic          s_req_ready, s_rsp_valid, s_bus_req, s_bus_we, s_bus_atomic;
   logic [DW-1:0] s_rsp_rdata, s_bus_wdata, s_bus_rdata;
   logic [AW-1:0] s_bus_addr;
   logic          s_gnt = 1'b0;

   assign bus_gnt     = gnt_all | (gnt_rd & ~bus_we);
   assign bus_rdata   = {8'hA5, bus_addr};
   assign s_bus_rdata = {8'hA5, s_bus_addr};

   tso_store_buffer #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4), .BYPASS_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_req(bus_req),
      .bus_we(bus_we), .bus_atomic(bus_atomic), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata));

   tso_store_buffer #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4), .BYPASS_EN(1'b0)) dut_sc (
      .clk(clk), .rst_n(rst_n), .req_valid(s_req_valid), .req_op(s_req_op),
      .req_addr(s_req_addr), .req_wdata(s_req_wdata), .req_ready(s_req_ready),
      .rsp_valid(s_rsp_valid), .rsp_rdata(s_rsp_rdata), .bus_req(s_bus_req),
      .bus_we(s_bus_we), .bus_atomic(s_bus_atomic), .bus_addr(s_bus_addr),
      .bus_wdata(s_bus_wdata), .bus_gnt(s_gnt), .bus_rdata(s_bus_rdata));

   // write log of the bus side
   logic [AW-1:0] wlog [256];
   logic [DW-1:0] wdat [256];
   int wcnt = 0, s_wcnt = 0;
   always @(posedge clk) begin
      if (bus_req && bus_gnt && bus_we) begin
         wlog[wcnt % 256] = bus_addr;
         wdat[wcnt % 256] = bus_wdata;
         wcnt++;
      end
      if (s_bus_req && s_gnt && s_bus_we) s_wcnt++;
   end

   int nchk = 0, nerr = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   endtask

   task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [1:0] op, input int limit, output int waited);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
      #1;
      waited = 0;
      while (!req_ready && waited < limit) begin @(negedge clk); #1; waited++; end
      if (req_ready) begin
         @(posedge clk); #1; req_valid = 1'b0;
      end else begin
         req_valid = 1'b0; waited = 99;
      end
   endtask

   task automatic do_load(input logic [AW-1:0] a, input int limit, input bit open_all,
                          output int waited, output logic got, output logic [DW-1:0] data);
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'b00; req_addr = a;
      if (open_all) gnt_all = 1'b1;
      #1;
      waited = 0;
      while (!req_ready && waited < limit) begin @(negedge clk); #1; waited++; end
      if (req_ready) begin
         @(posedge clk); #1; req_valid = 1'b0;
         @(negedge clk);
         got = rsp_valid; data = rsp_rdata;
      end else begin
         req_valid = 1'b0; got = 1'b0; data = '0; waited = 99;
      end
   endtask

   initial begin
      #(200000 * 5);
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int w, base;
      logic got;
      logic [DW-1:0] rd;
      logic [AW-1:0] la;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: quiet after reset, store taken at once
      chk("R10 bus_req", bus_req, 0);
      chk("R10 rsp_valid", rsp_valid, 0);
      chk("R10 sc bus_req", s_bus_req, 0);
      req_valid = 1'b1; req_op = 2'b01; req_addr = 8'h02; #1;
      chk("R10 ready", req_ready, 1);
      req_valid = 1'b0;

      // Sweep: fill level k, load probing slot j (j==k: no match)
      for (int k = 1; k <= 4; k++) begin
         for (int j = 0; j <= k; j++) begin
            gnt_all = 1'b0; gnt_rd = 1'b1;
            base = wcnt;
            for (int i = 0; i < k; i++) begin
               do_wr(AW'(8'h10 * (i + 1)), DW'(16'h100 * k + 16'h10 * j + i), 2'b01, 5, w);
               chk("R2 store accepted without grant", w, 0);
            end
            if (k == 4 && j == 0) begin
               do_wr(8'hE0, 16'hDEAD, 2'b01, 3, w);
               chk("R3 full stalls store", w, 99);
            end
            la = (j < k) ? AW'(8'h10 * (j + 1) + 1) : 8'hF1;
            do_load(la, 3, 1'b0, w, got, rd);
            if (j == k) begin
               chk("R4 bypass load issued", got, 1);
               chk("R4 bypass data", rd, {8'hA5, la});
               chk("R4 no writes before bypass", wcnt - base, 0);
               @(negedge clk);
               chk("R9 rsp one cycle", rsp_valid, 0);
               gnt_all = 1'b1;
            end else begin
               chk("R6 byte-offset load held (R5)", w, 99);
               do_load(la, 20, 1'b1, w, got, rd);
               chk("R5 held load completes", got, 1);
               chk("R9 held load data", rd, {8'hA5, la});
               chk("R5 writes drained before load", wcnt - base, j + 1);
            end
            repeat (k + 3) @(negedge clk);
            chk("R1 all writes out", wcnt - base, k);
            for (int i = 0; i < k; i++) begin
               chk("R1 write order addr", wlog[(base + i) % 256], 8'h10 * (i + 1));
               chk("R1 write order data", wdat[(base + i) % 256],
                   16'h100 * k + 16'h10 * j + i);
            end
         end
      end

      // R7: atomic behind a store
      gnt_all = 1'b0; gnt_rd = 1'b0;
      base = wcnt;
      do_wr(8'h60, 16'h6666, 2'b01, 5, w);
      chk("R2 store before atomic", w, 0);
      do_wr(8'h70, 16'h7777, 2'b10, 5, w);
      chk("R2 atomic accepted", w, 0);
      do_wr(8'h80, 16'h8888, 2'b01, 3, w);
      chk("R7 request blocked by atomic", w, 99);
      chk("R7 no early response", rsp_valid, 0);
      @(negedge clk);
      gnt_all = 1'b1;
      w = 0;
      @(negedge clk);
      while (!rsp_valid && w < 10) begin @(negedge clk); w++; end
      chk("R7 atomic responds", rsp_valid, 1);
      chk("R9 atomic data", rsp_rdata, {8'hA5, 8'h70});
      chk("R7 older store and atomic out", wcnt - base, 2);
      chk("R1 store before atomic", wlog[base % 256], 8'h60);
      chk("R1 atomic write", wlog[(base + 1) % 256], 8'h70);
      do_wr(8'h90, 16'h9999, 2'b01, 5, w);
      chk("R7 requests resume", w, 0);
      repeat (4) @(negedge clk);

      // R11: reserved code
      base = wcnt;
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'b11; req_addr = 8'h44;
      for (int c = 0; c < 3; c++) begin
         #1;
         chk("R11 reserved not ready", req_ready, 0);
         chk("R11 reserved no bus", bus_req, 0);
         @(negedge clk);
      end
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk("R11 nothing written", wcnt - base, 0);

      // R8: no bypass in the sequentially consistent instance
      s_gnt = 1'b0;
      base = s_wcnt;
      @(negedge clk);
      s_req_valid = 1'b1; s_req_op = 2'b01; s_req_addr = 8'h10; s_req_wdata = 16'h1234;
      #1;
      chk("R2 sc store accepted", s_req_ready, 1);
      @(posedge clk); #1; s_req_valid = 1'b0;
      @(negedge clk);
      s_req_valid = 1'b1; s_req_op = 2'b00; s_req_addr = 8'h80;
      for (int c = 0; c < 3; c++) begin
         #1;
         chk("R8 sc load held", s_req_ready, 0);
         chk("R8 sc bus shows write", s_bus_we, 1);
         @(negedge clk);
      end
      s_gnt = 1'b1;
      w = 0;
      #1;
      while (!s_req_ready && w < 10) begin @(negedge clk); #1; w++; end
      chk("R8 sc load issued", s_req_ready, 1);
      chk("R8 sc store first", s_wcnt - base, 1);
      @(posedge clk); #1; s_req_valid = 1'b0;
      @(negedge clk);
      chk("R9 sc load response", s_rsp_valid, 1);
      chk("R9 sc load data", s_rsp_rdata, {8'hA5, 8'h80});

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule